// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block watches a parameterised number of GPIO banks, each up to 32 pins wide, and turns pin activity into latched interrupt flags. Every pin has three configuration bits of its own. One bit picks level or edge sensing. One bit picks the active sense: high/rising or low/falling. One bit makes an edge-mode pin fire on any transition. Each pin input passes through a resettable synchronizer chain before detection. Edges are found by comparing the newest synchronized sample with the one before it.

Software reaches the block through a plain synchronous word bus. Each bank owns eight word slots, and the bank number sits in the upper address bits. Enables are changed through two write-only masks, one that sets bits and one that clears them, so no read-modify-write is needed. A separate read-only view shows the enables. Pending flags are cleared by writing ones. A single registered interrupt line reports whether any bank has a flag that is both pending and enabled.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every enable bit, every trigger configuration bit, the synchronizer stages and `irq_o` are 0. With the default configuration (level, low), pins held high through reset therefore leave every status bit set once, yet `irq_o` stays 0.
- R2: Writing the set-mask slot (word offset 0 of a bank) sets the enable of each pin whose data bit is 1; pins written with 0 keep their enable.
- R3: Writing the clear-mask slot (offset 1) clears the enable of each pin whose data bit is 1; pins written with 0 keep their enable.
- R4: Offset 2 reads the enable bits, offset 3 reads the status bits. Offsets 4, 5 and 6 are read/write and hold the per-pin edge-select bit (1 = edge, 0 = level), sense bit (1 = high/rising, 0 = low/falling) and dual-edge bit. Offsets 0, 1 and 7 read as 0.
- R5: Writing offset 3 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R6: In level mode a status bit is set on every cycle in which the synchronized pin equals its sense bit. A clear written while that level persists leaves the bit set.
- R7: In edge mode with dual-edge 0, a rising edge sets the bit when sense is 1, and a falling edge sets it when sense is 0. The opposite edge has no effect.
- R8: In edge mode with dual-edge 1, both edges set the bit whatever the sense bit holds.
- R9: `irq_o` is the OR over all banks of status AND enable, registered once. A pending bit that is not enabled does not raise it, disabling a pin drops it, and disabling does not clear the status bit.
- R10: When a detected event and a clear write hit the same pin in the same cycle, the status bit ends up set.
- R11: Bank b occupies word addresses 8*b to 8*b+7. A write to one bank changes no other bank. Writes to a bank number at or above NUM_BANKS are ignored, and reads there return 0.
- R12: With the default two-stage synchronizer, a pin change made before rising clock edge k sets the status bit at edge k+2 and raises `irq_o` at edge k+3.
- R13: Read data is registered: `bus_rdata` shows the selected word after the edge at which `bus_rd_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_BANKS*PINS | Raw pin levels, bank b at bits b*PINS upward |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address: bank in upper bits, slot in low 3 bits |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The functions that can collide are pin detection and the software clear of the status register: both act on a status bit at the same clock edge. The bench provokes this by toggling a dual-edge pin and then placing a write-one-to-clear so that it is sampled on the exact edge where the synchronized edge is seen. It then reads the flag back and expects it set. A second clear with no event present must then leave the flag at 0. A persistent active level combined with a clear is judged the same way.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      SLOT_ENA_SET  = 3'd0,
      SLOT_ENA_CLR  = 3'd1,
      SLOT_ENA_VIEW = 3'd2,
      SLOT_PENDING  = 3'd3,
      SLOT_EDGE_SEL = 3'd4,
      SLOT_HI_SEL   = 3'd5,
      SLOT_DUAL     = 3'd6,
      SLOT_SPARE    = 3'd7
   } slot_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W     = 32,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   logic [DEPTH-1:0][W-1:0] stage_q;
   logic [W-1:0]            prev_q;

   initial begin
      assert (DEPTH >= 2) else $error("gpio_irq_sync: DEPTH must be at least 2");
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= din_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[DEPTH-1];

   assign cur_o  = stage_q[DEPTH-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig #(
   parameter int W = 32
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] prev_i,
   input  logic [W-1:0] edge_sel_i,
   input  logic [W-1:0] hi_sel_i,
   input  logic [W-1:0] dual_i,
   output logic [W-1:0] evt_o
);
   for (genvar p = 0; p < W; p++) begin : g_pin
      logic rise, fall, lvl_hit, edg_hit;
      assign rise    = cur_i[p] & ~prev_i[p];
      assign fall    = ~cur_i[p] & prev_i[p];
      assign lvl_hit = (cur_i[p] == hi_sel_i[p]);
      assign edg_hit = dual_i[p] ? (rise | fall) : (hi_sel_i[p] ? rise : fall);
      assign evt_o[p] = edge_sel_i[p] ? edg_hit : lvl_hit;
   end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int PINS       = 32,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PINS-1:0]   pins_i,
   input  logic              wr_sel_i,
   input  logic [REG_AW-1:0] reg_idx_i,
   input  logic [PINS-1:0]   wdata_i,
   output logic [PINS-1:0]   rd_word_o,
   output logic              pend_o
);
   slot_e           slot;
   logic [PINS-1:0] cur, prev, evt;
   logic [PINS-1:0] ena_q, sts_q, edge_q, hi_q, dual_q;
   logic [PINS-1:0] clr_mask;
   logic            ena_set_wr, ena_clr_wr, sts_wr;

   assign slot = slot_e'(reg_idx_i);

   gpio_irq_sync #(.W(PINS), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_i  (pins_i),
      .cur_o  (cur),
      .prev_o (prev)
   );

   gpio_irq_trig #(.W(PINS)) u_trig (
      .cur_i      (cur),
      .prev_i     (prev),
      .edge_sel_i (edge_q),
      .hi_sel_i   (hi_q),
      .dual_i     (dual_q),
      .evt_o      (evt)
   );

   assign ena_set_wr = wr_sel_i && (slot == SLOT_ENA_SET);
   assign ena_clr_wr = wr_sel_i && (slot == SLOT_ENA_CLR);
   assign sts_wr     = wr_sel_i && (slot == SLOT_PENDING);
   assign clr_mask   = sts_wr ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q  <= '0;
         edge_q <= '0;
         hi_q   <= '0;
         dual_q <= '0;
      end else if (wr_sel_i) begin
         case (slot)
            SLOT_ENA_SET:  ena_q  <= ena_q | wdata_i;
            SLOT_ENA_CLR:  ena_q  <= ena_q & ~wdata_i;
            SLOT_EDGE_SEL: edge_q <= wdata_i;
            SLOT_HI_SEL:   hi_q   <= wdata_i;
            SLOT_DUAL:     dual_q <= wdata_i;
            default: ;
         endcase
      end
   end

   // new events take precedence over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_mask) | evt;

   always_comb begin
      case (slot)
         SLOT_ENA_VIEW: rd_word_o = ena_q;
         SLOT_PENDING:  rd_word_o = sts_q;
         SLOT_EDGE_SEL: rd_word_o = edge_q;
         SLOT_HI_SEL:   rd_word_o = hi_q;
         SLOT_DUAL:     rd_word_o = dual_q;
         default:       rd_word_o = '0;
      endcase
   end

   assign pend_o = |(sts_q & ena_q);

   assert_ena_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ena_set_wr |=> ((ena_q & $past(wdata_i)) == $past(wdata_i)) &&
                     ((ena_q & ~$past(wdata_i)) == ($past(ena_q) & ~$past(wdata_i))))
      else $error("enable set mask misbehaved");

   assert_ena_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ena_clr_wr |=> ((ena_q & $past(wdata_i)) == '0) &&
                     ((ena_q & ~$past(wdata_i)) == ($past(ena_q) & ~$past(wdata_i))))
      else $error("enable clear mask misbehaved");

   assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sts_wr |=> ((sts_q & $past(wdata_i & ~evt)) == '0))
      else $error("status clear left a bit set");

   assert_evt_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((sts_q & $past(evt)) == $past(evt)))
      else $error("detected event was lost");
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int NUM_BANKS  = 3,
   parameter int PINS       = 32,
   parameter int ADDR_W     = 5,
   parameter int SYNC_DEPTH = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_BANKS*PINS-1:0] pins_i,
   input  logic                      bus_wr_en,
   input  logic                      bus_rd_en,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [PINS-1:0]           bus_wdata,
   output logic [PINS-1:0]           bus_rdata,
   output logic                      irq_o
);
   localparam int BANK_AW = ADDR_W - REG_AW;

   initial begin
      assert (NUM_BANKS >= 1) else $error("NUM_BANKS must be positive");
      assert (PINS >= 1 && PINS <= 32) else $error("PINS must be 1..32");
      assert (SYNC_DEPTH >= 2) else $error("SYNC_DEPTH must be at least 2");
      assert (BANK_AW >= 1 && (1 << BANK_AW) >= NUM_BANKS)
         else $error("ADDR_W too small for NUM_BANKS");
   end

   logic [BANK_AW-1:0]                bank_idx;
   logic [REG_AW-1:0]                 reg_idx;
   logic [NUM_BANKS-1:0][PINS-1:0]    rd_word;
   logic [NUM_BANKS-1:0]              pend;
   logic [PINS-1:0]                   rd_sel;

   assign bank_idx = bus_addr[ADDR_W-1:REG_AW];
   assign reg_idx  = bus_addr[REG_AW-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_sel;
      assign wr_sel = bus_wr_en && (bank_idx == BANK_AW'(b));

      gpio_irq_bank #(.PINS(PINS), .SYNC_DEPTH(SYNC_DEPTH)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .pins_i    (pins_i[b*PINS +: PINS]),
         .wr_sel_i  (wr_sel),
         .reg_idx_i (reg_idx),
         .wdata_i   (bus_wdata),
         .rd_word_o (rd_word[b]),
         .pend_o    (pend[b])
      );
   end

   always_comb begin
      rd_sel = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (bank_idx == BANK_AW'(b)) rd_sel = rd_word[b];
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_sel;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |pend;

   assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(|pend)))
      else $error("irq does not track pending enables");

   assert_irq_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !irq_o)
      else $error("irq raised with nothing enabled and pending");
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
   localparam int NB = 3;
   localparam int PW = 32;
   localparam int AW = 5;

   localparam int S_SET  = 0;
   localparam int S_CLR  = 1;
   localparam int S_VIEW = 2;
   localparam int S_PEND = 3;
   localparam int S_EDGE = 4;
   localparam int S_HI   = 5;
   localparam int S_DUAL = 6;
   localparam int S_SPR  = 7;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NB*PW-1:0]   pins = '1;
   logic               wr_en = 1'b0;
   logic               rd_en = 1'b0;
   logic [AW-1:0]      addr = '0;
   logic [PW-1:0]      wdata = '0;
   logic [PW-1:0]      rdata;
   logic               irq;

   int checks = 0;
   int bad = 0;
   bit done = 0;
   logic rd_q = 1'b0;
   logic [PW-1:0] exp_q[$];
   string         tag_q[$];

   always #4 clk = ~clk;

   gpio_irq_detect #(.NUM_BANKS(NB), .PINS(PW), .ADDR_W(AW), .SYNC_DEPTH(2)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_i    (pins),
      .bus_wr_en (wr_en),
      .bus_rd_en (rd_en),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_o     (irq)
   );

   task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: one read result per sampled read strobe (R13)
   always @(posedge clk) rd_q <= rd_en;
   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) chk("R13 unexpected read", rdata, 'x);
         else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic wr(input int b, input int s, input logic [PW-1:0] d);
      wr_en = 1'b1; addr = AW'(b * 8 + s); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int b, input int s, input logic [PW-1:0] e, input string req);
      rd_en = 1'b1; addr = AW'(b * 8 + s);
      exp_q.push_back(e); tag_q.push_back(req);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      idle(4);

      // R1: reset state
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      for (int b = 0; b < NB; b++) rd(b, S_VIEW, 32'h0, "R1 enables zero");
      rd(0, S_EDGE, 32'h0, "R1 edge sel zero");
      rd(0, S_HI, 32'h0, "R1 sense zero");
      rd(0, S_DUAL, 32'h0, "R1 dual zero");
      rd(0, S_PEND, 32'hFFFF_FFFF, "R1 startup level-low status");
      chk("R1 irq low while disabled", {31'b0, irq}, 32'h0);
      rd(0, S_SET, 32'h0, "R4 set slot reads zero");
      rd(0, S_SPR, 32'h0, "R4 spare slot reads zero");

      // R5: partial and full write-one-to-clear
      wr(0, S_PEND, 32'h0000_FFFF);
      rd(0, S_PEND, 32'hFFFF_0000, "R5 partial clear");
      wr(0, S_PEND, 32'hFFFF_0000);
      rd(0, S_PEND, 32'h0, "R5 full clear");
      wr(1, S_PEND, '1);
      wr(2, S_PEND, '1);
      rd(1, S_PEND, 32'h0, "R5 bank1 clear");

      // R2 R3 R4: enable masks
      wr(0, S_SET, 32'h0000_00F0);
      wr(0, S_SET, 32'h0000_0003);
      rd(0, S_VIEW, 32'h0000_00F3, "R2 set keeps zeros");
      wr(0, S_CLR, 32'h0000_0030);
      rd(0, S_VIEW, 32'h0000_00C3, "R3 clear selected");
      wr(0, S_CLR, 32'h0);
      rd(0, S_VIEW, 32'h0000_00C3, "R3 zero mask keeps");
      wr(0, S_CLR, '1);
      rd(0, S_VIEW, 32'h0, "R3 clear all");

      // configure bank0: p0 level high, p1 rise, p2 fall, p3 dual, p4 level low
      pins[0] = 1'b0;
      idle(4);
      wr(0, S_EDGE, 32'h0000_000E);
      wr(0, S_HI,   32'h0000_000B);
      wr(0, S_DUAL, 32'h0000_0008);
      wr(0, S_PEND, '1);
      rd(0, S_EDGE, 32'h0000_000E, "R4 edge sel readback");
      rd(0, S_HI,   32'h0000_000B, "R4 sense readback");
      rd(0, S_DUAL, 32'h0000_0008, "R4 dual readback");
      rd(0, S_PEND, 32'h0, "R6 idle pins no status");

      // R7 rising
      pins[1] = 1'b0; idle(4);
      rd(0, S_PEND, 32'h0, "R7 falling ignored in rise mode");
      pins[1] = 1'b1; idle(4);
      rd(0, S_PEND, 32'h2, "R7 rising sets");
      wr(0, S_PEND, 32'h2);
      // R7 falling
      pins[2] = 1'b0; idle(4);
      rd(0, S_PEND, 32'h4, "R7 falling sets");
      wr(0, S_PEND, 32'h4);
      pins[2] = 1'b1; idle(4);
      rd(0, S_PEND, 32'h0, "R7 rising ignored in fall mode");
      // R8 dual
      pins[3] = 1'b0; idle(4);
      rd(0, S_PEND, 32'h8, "R8 falling sets");
      wr(0, S_PEND, 32'h8);
      pins[3] = 1'b1; idle(4);
      rd(0, S_PEND, 32'h8, "R8 rising sets");
      wr(0, S_PEND, 32'h8);

      // R6 level
      pins[0] = 1'b1; idle(4);
      rd(0, S_PEND, 32'h1, "R6 level high sets");
      wr(0, S_PEND, 32'h1);
      rd(0, S_PEND, 32'h1, "R6 clear under held level");
      pins[0] = 1'b0; idle(4);
      wr(0, S_PEND, 32'h1);
      rd(0, S_PEND, 32'h0, "R6 clear after level gone");
      pins[4] = 1'b0; idle(4);
      rd(0, S_PEND, 32'h10, "R6 level low sets");
      pins[4] = 1'b1; idle(4);
      wr(0, S_PEND, 32'h10);
      rd(0, S_PEND, 32'h0, "R6 level low cleared");

      // R12 R9 latency and irq
      pins[1] = 1'b0; idle(4);
      wr(0, S_SET, 32'h2);
      idle(2);
      chk("R9 enabled but not pending", {31'b0, irq}, 32'h0);
      pins[1] = 1'b1;
      idle(3);
      chk("R12 irq not before edge k+3", {31'b0, irq}, 32'h0);
      idle(1);
      chk("R12 irq at edge k+3", {31'b0, irq}, 32'h1);
      wr(0, S_CLR, 32'h2);
      idle(1);
      chk("R9 disable drops irq", {31'b0, irq}, 32'h0);
      rd(0, S_PEND, 32'h2, "R9 disable keeps status");
      wr(0, S_SET, 32'h2);
      idle(1);
      chk("R9 re-enable raises irq", {31'b0, irq}, 32'h1);
      wr(0, S_PEND, 32'h2);
      idle(1);
      chk("R9 clear drops irq", {31'b0, irq}, 32'h0);

      // R10 event and clear in the same cycle
      pins[3] = 1'b0; idle(4);
      pins[3] = 1'b1;
      idle(2);
      wr(0, S_PEND, 32'h8);
      rd(0, S_PEND, 32'h8, "R10 event wins over clear");
      wr(0, S_PEND, 32'h8);
      rd(0, S_PEND, 32'h0, "R10 plain clear");

      // R11 banking
      pins[PW + 7] = 1'b0; idle(4);
      rd(1, S_PEND, 32'h80, "R11 bank1 status");
      rd(0, S_PEND, 32'h0, "R11 bank0 untouched");
      rd(2, S_PEND, 32'h0, "R11 bank2 untouched");
      wr(1, S_SET, 32'h80);
      idle(1);
      chk("R9 irq from bank1", {31'b0, irq}, 32'h1);
      wr(3, S_SET, '1);
      rd(3, S_VIEW, 32'h0, "R11 unmapped bank reads zero");
      rd(0, S_VIEW, 32'h2, "R11 bank0 enables intact");
      rd(2, S_VIEW, 32'h0, "R11 bank2 enables intact");
      pins[PW + 7] = 1'b1; idle(4);
      wr(1, S_PEND, 32'h80);
      idle(1);
      chk("R9 irq cleared bank1", {31'b0, irq}, 32'h0);
      wr(2, S_HI, 32'hA5A5_0000);
      rd(2, S_HI, 32'hA5A5_0000, "R11 bank2 sense");
      rd(0, S_HI, 32'h0000_000B, "R11 bank0 sense intact");

      idle(3);
      chk("R13 all reads returned", 32'(exp_q.size()), 32'h0);
      finish_run();
   end
endmodule